// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a small 8-bit microcontroller into a single core reset. The requests are a power-on event, a supply-monitor trip, a low level on the external reset pin, a missing-clock timeout, a comparator result, a watchdog timeout and a software request. The core reset stays asserted while any qualified request is present and for a fixed number of cycles after the last one goes away. The block also drives an open-drain pull-down on the external reset pin, but only for a supply-monitor reset.

A one-hot cause register records which request started the most recent reset, and software reads it on `status`. A write to that register position does not set cause bits. Instead, three of its bits act as enable controls: bit 1 turns on the supply monitor, bit 2 enables or disables the missing-clock detector, and bit 5 enables or disables the comparator reset. Only a power-on event turns the supply monitor off again. When the monitor is switched on from the off state, its trip input is masked for a settling window.

The block also owns the watchdog enable and a divide-by-12 prescaler tick for the watchdog counter. After every reset the watchdog comes back enabled.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low: `core_rst` is 1, `pin_pull_low` is 1, `status` reads 0x02, `supmon_en`, `mcd_en` and `cmp_rst_en` read 0, and `wdt_en` reads 1. After `por_n` rises, `core_rst` eventually falls and `status` still reads 0x02.
- R2: Each clock edge at which a qualified request is present counts as an active edge. `core_rst` is high after every active edge and after each of the HOLD_CYC (16) edges that follow the last one. The total number of high cycles for one request episode is therefore the number of active edges plus HOLD_CYC.
- R3: A supply-monitor trip counts when the monitor is enabled and its settling window has ended. Sampled at an edge, it raises `core_rst` and `pin_pull_low` after that edge and records cause bit 1 (status 0x02). `pin_pull_low` stays high for every edge at which the trip is still present.
- R4: Writing `reg_wdata` with bit 1 set turns `supmon_en` on. No write clears it, and no reset except `por_n` clears it. While the monitor is off, `supmon_trip` has no effect.
- R5: When `supmon_en` is turned on from 0 at edge W, a trip has no effect at edges W+1 through W+SETTLE_CYC (8). A trip at edge W+SETTLE_CYC+1 starts a reset.
- R6: `rst_pin_n` passes through a two-flop synchronizer. A low level held for L edges gives L active edges starting two edges later, and records cause bit 0 (status 0x01).
- R7: Bit 2 of a write sets or clears `mcd_en`. When `mcd_en` is 1, `clk_stall` high starts a reset with cause bit 2 (status 0x04). When `mcd_en` is 0, `clk_stall` has no effect.
- R8: Bit 5 of a write sets or clears `cmp_rst_en`. `cmp_out` = 0 means the non-inverting input is below the inverting input. With `cmp_rst_en` = 1, that starts a reset with cause bit 5 (status 0x20).
- R9: `wdt_expire` starts a reset with cause bit 3 (status 0x08), and `sw_rst_req` starts one with cause bit 4 (status 0x10). Pin, missing-clock, comparator, watchdog and software resets never assert `pin_pull_low`.
- R10: Exactly one status bit is set at all times. The cause is captured only on the edge where the reset is entered. Simultaneous requests rank as supply monitor, then missing clock, then comparator, then watchdog, then software, then pin. Requests that arrive during the hold extend it but do not change `status`.
- R11: Entering any reset clears `mcd_en` and `cmp_rst_en` and sets `wdt_en`. While `wdt_en` is 1 and the core is out of reset, `wdt_tick` pulses once every 12 cycles. A `wdt_disable` pulse clears `wdt_en` and stops the ticks.
- R12: Writes made while `core_rst` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| supmon_trip | input | 1 | Supply below threshold |
| rst_pin_n | input | 1 | Level sensed on the external reset pin |
| clk_stall | input | 1 | Missing-clock detector timeout |
| cmp_out | input | 1 | Comparator output, 0 when + input is below - input |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| sw_rst_req | input | 1 | Software reset request |
| wdt_disable | input | 1 | Software request to stop the watchdog |
| reg_wr | input | 1 | Write strobe for the cause/enable register |
| reg_wdata | input | 8 | Write data |
| status | output | 8 | One-hot cause of the last reset |
| core_rst | output | 1 | Core reset, active high |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the reset pin |
| supmon_en | output | 1 | Supply monitor enabled |
| mcd_en | output | 1 | Missing-clock detector enabled |
| cmp_rst_en | output | 1 | Comparator reset enabled |
| wdt_en | output | 1 | Watchdog enabled |
| wdt_tick | output | 1 | Watchdog clock enable, one cycle in 12 |

## Verification
The hardest case to reach is a supply-monitor reset. The block's own pull-down drags the pin low, and that low level comes back through the synchronizer as a late pin request. That request stretches the hold but must not replace the recorded cause. The bench models the pin as an open-drain wire that combines its own pull-down with `pin_pull_low`, so the feedback path is real. It then sweeps every combination of simultaneous internal requests and compares the measured hold length against one plus three plus HOLD_CYC whenever the supply monitor is part of the mix. The settling window is reached by holding the trip high before the monitor is enabled, then checking each masked edge one by one.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int CAUSE_W = 6;

  // cause/enable register bit positions (software decodes these)
  localparam int BIT_PIN = 0;
  localparam int BIT_SUP = 1;
  localparam int BIT_MCD = 2;
  localparam int BIT_WDT = 3;
  localparam int BIT_SW  = 4;
  localparam int BIT_CMP = 5;

  typedef logic [CAUSE_W-1:0] cause_t;

  // qualified request vector
  typedef struct packed {
    logic sup;
    logic mcd;
    logic cmp;
    logic wdt;
    logic sw;
    logic pin;
  } src_t;

  // fixed ranking of simultaneous requests
  function automatic cause_t rank_cause(input src_t s);
    cause_t c;
    c = '0;
    if (s.sup)      c[BIT_SUP] = 1'b1;
    else if (s.mcd) c[BIT_MCD] = 1'b1;
    else if (s.cmp) c[BIT_CMP] = 1'b1;
    else if (s.wdt) c[BIT_WDT] = 1'b1;
    else if (s.sw)  c[BIT_SW]  = 1'b1;
    else            c[BIT_PIN] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstctl_srcq.sv
module rstctl_srcq import rstctl_pkg::*; #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic supmon_en,
  input  logic supmon_trip,
  input  logic mcd_en,
  input  logic clk_stall,
  input  logic cmp_en,
  input  logic cmp_out,
  input  logic wdt_expire,
  input  logic sw_rst_req,
  input  logic pin_low,
  output src_t src,
  output logic settle_busy
);

  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] settle_q;
  logic [SW-1:0] settle_d;

  always_comb begin
    settle_busy = (settle_q != '0);
    if (arm)              settle_d = SW'(SETTLE_CYC);
    else if (settle_busy) settle_d = settle_q - 1'b1;
    else                  settle_d = settle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  always_comb begin
    src.sup = supmon_en & ~settle_busy & supmon_trip;
    src.mcd = mcd_en & clk_stall;
    src.cmp = cmp_en & ~cmp_out;
    src.wdt = wdt_expire;
    src.sw  = sw_rst_req;
    src.pin = pin_low;
  end

  AST_ARM_STARTS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> settle_busy); // R5

endmodule

// File: rtl/rstctl_hold.sv
module rstctl_hold import rstctl_pkg::*; #(
  parameter int HOLD_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  src_t   src,
  output logic   core_rst,
  output logic   pin_pull,
  output logic   entry,
  output cause_t cause
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;
  logic          pull_q, pull_d;
  cause_t        cause_q, cause_d;
  logic          any_src;

  always_comb begin
    any_src = |src;
    entry   = any_src & ~rst_q;
    if (any_src)             cnt_d = CW'(HOLD_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
    rst_d   = any_src | (cnt_q != '0);
    pull_d  = src.sup;
    cause_d = entry ? rank_cause(src) : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(HOLD_CYC);
      rst_q   <= 1'b1;
      pull_q  <= 1'b1;
      cause_q <= cause_t'(1 << BIT_SUP);
    end else begin
      cnt_q   <= cnt_d;
      rst_q   <= rst_d;
      pull_q  <= pull_d;
      cause_q <= cause_d;
    end
  end

  assign core_rst = rst_q;
  assign pin_pull = pull_q;
  assign cause    = cause_q;

  AST_SRC_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> core_rst); // R2
  AST_PULL_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull |-> core_rst); // R3
  AST_PULL_ONLY_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pull) |-> $past(src.sup)); // R9
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cause)); // R10
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> $stable(cause)); // R10

endmodule

// File: rtl/rstctl_wdtpre.sv
module rstctl_wdtpre #(
  parameter int WDT_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_rst,
  input  logic wdt_disable,
  output logic wdt_en,
  output logic wdt_tick
);

  localparam int PW = $clog2(WDT_DIV);

  logic [PW-1:0] pre_q, pre_d;
  logic          en_q, en_d;
  logic          tick_q, tick_d;
  logic          run;
  logic          wrap;

  always_comb begin
    run  = en_q & ~core_rst;
    wrap = (pre_q == PW'(WDT_DIV - 1));
    if (core_rst)         en_d = 1'b1;
    else if (wdt_disable) en_d = 1'b0;
    else                  en_d = en_q;
    if (!run)      pre_d = '0;
    else if (wrap) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
    tick_d = run & wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      en_q   <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      en_q   <= en_d;
      tick_q <= tick_d;
    end
  end

  assign wdt_en   = en_q;
  assign wdt_tick = tick_q;

  AST_WDT_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> wdt_en); // R11
  AST_NO_TICK_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !wdt_tick); // R11

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top import rstctl_pkg::*; #(
  parameter int HOLD_CYC    = 16,
  parameter int SETTLE_CYC  = 8,
  parameter int WDT_DIV     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supmon_trip,
  input  logic       rst_pin_n,
  input  logic       clk_stall,
  input  logic       cmp_out,
  input  logic       wdt_expire,
  input  logic       sw_rst_req,
  input  logic       wdt_disable,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] status,
  output logic       core_rst,
  output logic       pin_pull_low,
  output logic       supmon_en,
  output logic       mcd_en,
  output logic       cmp_rst_en,
  output logic       wdt_en,
  output logic       wdt_tick
);

  logic   rst_n;
  logic   pin_s;
  src_t   src;
  logic   settle_busy;
  logic   entry;
  cause_t cause;
  logic   wr_ok;
  logic   arm;
  logic   sup_q, sup_d;
  logic   mcd_q, mcd_d;
  logic   cmp_q, cmp_d;
  logic   unused_wdata;

  // power-on: asserted at once, released on the clock
  rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(rst_n), .d(rst_pin_n), .q(pin_s)
  );

  always_comb begin
    wr_ok = reg_wr & ~core_rst;
    arm   = wr_ok & reg_wdata[BIT_SUP] & ~sup_q;
    sup_d = sup_q | (wr_ok & reg_wdata[BIT_SUP]);
    if (entry)      mcd_d = 1'b0;
    else if (wr_ok) mcd_d = reg_wdata[BIT_MCD];
    else            mcd_d = mcd_q;
    if (entry)      cmp_d = 1'b0;
    else if (wr_ok) cmp_d = reg_wdata[BIT_CMP];
    else            cmp_d = cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= 1'b0;
      mcd_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      sup_q <= sup_d;
      mcd_q <= mcd_d;
      cmp_q <= cmp_d;
    end
  end

  assign unused_wdata = ^{reg_wdata[7:6], reg_wdata[4:3], reg_wdata[0]};

  rstctl_srcq #(.SETTLE_CYC(SETTLE_CYC)) u_srcq (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .supmon_en(sup_q), .supmon_trip(supmon_trip),
    .mcd_en(mcd_q), .clk_stall(clk_stall),
    .cmp_en(cmp_q), .cmp_out(cmp_out),
    .wdt_expire(wdt_expire), .sw_rst_req(sw_rst_req),
    .pin_low(~pin_s), .src(src), .settle_busy(settle_busy)
  );

  rstctl_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .src(src),
    .core_rst(core_rst), .pin_pull(pin_pull_low),
    .entry(entry), .cause(cause)
  );

  rstctl_wdtpre #(.WDT_DIV(WDT_DIV)) u_wdt (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
    .wdt_disable(wdt_disable), .wdt_en(wdt_en), .wdt_tick(wdt_tick)
  );

  assign status     = {{(8-CAUSE_W){1'b0}}, cause};
  assign supmon_en  = sup_q;
  assign mcd_en     = mcd_q;
  assign cmp_rst_en = cmp_q;

  AST_SUPMON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(supmon_en)); // R4
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> ($stable(mcd_en) && $stable(cmp_rst_en))); // R12
  AST_SETTLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |=> !$rose(pin_pull_low)); // R5
  AST_ENTRY_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> (!mcd_en && !cmp_rst_en)); // R11

endmodule

// File: tb/tb_rstctl_top.sv
module tb_rstctl_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;
  localparam int SETTLE     = 8;
  localparam int DIV        = 12;

  logic       clk;
  logic       por_n, supmon_trip, clk_stall, cmp_out, wdt_expire;
  logic       sw_rst_req, wdt_disable, reg_wr, ext_low;
  logic [7:0] reg_wdata;
  logic [7:0] status;
  logic       core_rst, pin_pull_low, supmon_en, mcd_en, cmp_rst_en;
  logic       wdt_en, wdt_tick;
  logic       pin_lvl;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  // open-drain pin: board pull-down or the block's own pull-down
  assign pin_lvl = ~(ext_low | pin_pull_low);

  rstctl_top dut (
    .clk(clk), .por_n(por_n), .supmon_trip(supmon_trip), .rst_pin_n(pin_lvl),
    .clk_stall(clk_stall), .cmp_out(cmp_out), .wdt_expire(wdt_expire),
    .sw_rst_req(sw_rst_req), .wdt_disable(wdt_disable), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status(status), .core_rst(core_rst),
    .pin_pull_low(pin_pull_low), .supmon_en(supmon_en), .mcd_en(mcd_en),
    .cmp_rst_en(cmp_rst_en), .wdt_en(wdt_en), .wdt_tick(wdt_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (!core_rst) break;
    end
    chk(req, core_rst, 0);
  endtask

  initial begin
    int cnt;
    por_n = 1'b0; supmon_trip = 1'b0; clk_stall = 1'b0; cmp_out = 1'b1;
    wdt_expire = 1'b0; sw_rst_req = 1'b0; wdt_disable = 1'b0;
    reg_wr = 1'b0; reg_wdata = 8'h00; ext_low = 1'b0;

    // R1: state during power-on
    repeat (3) @(negedge clk);
    chk("R1 core_rst", core_rst, 1);
    chk("R1 pull", pin_pull_low, 1);
    chk("R1 status", status, 8'h02);
    chk("R1 supmon_en", supmon_en, 0);
    chk("R1 mcd_en", mcd_en, 0);
    chk("R1 cmp_en", cmp_rst_en, 0);
    chk("R1 wdt_en", wdt_en, 1);
    por_n = 1'b1;
    wait_idle("R1 release");
    chk("R1 status after", status, 8'h02);
    chk("R1 pull after", pin_pull_low, 0);

    // R4: trip ignored while monitor off
    @(negedge clk);
    supmon_trip = 1'b1;
    cnt = 0;
    repeat (10) begin @(posedge clk); #1; if (core_rst) cnt++; end
    chk("R4 trip ignored when off", cnt, 0);

    // R5: enable with trip already high, settle window masks it
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R4 enable", supmon_en, 1);
    for (int k = 1; k <= SETTLE; k++) begin
      @(posedge clk); #1;
      chk("R5 masked edge", core_rst, 0);
    end
    @(posedge clk); #1;
    chk("R5 first honoured edge", core_rst, 1);
    chk("R3 pull", pin_pull_low, 1);
    chk("R3 status", status, 8'h02);
    cnt = 0;
    repeat (3) begin @(posedge clk); #1; if (pin_pull_low) cnt++; end
    chk("R3 pull while trip", cnt, 3);
    @(negedge clk);
    supmon_trip = 1'b0;
    wait_idle("R3 exit");
    chk("R3 pull released", pin_pull_low, 0);

    // R6: external pin low for L edges
    begin
      int hi;
      int pl;
      hi = 0; pl = 0;
      @(negedge clk);
      ext_low = 1'b1;
      for (int i = 0; i < 5 + HOLD + 20; i++) begin
        @(posedge clk); #1;
        if (core_rst) hi++;
        if (pin_pull_low) pl++;
        if (i == 4) begin @(negedge clk); ext_low = 1'b0; end
      end
      chk("R2 R6 pin hold length", hi, 5 + HOLD);
      chk("R6 status", status, 8'h01);
      chk("R9 no pull on pin reset", pl, 0);
    end

    // R7 R8: disabled detectors ignored
    @(negedge clk);
    clk_stall = 1'b1; cmp_out = 1'b0;
    cnt = 0;
    repeat (5) begin @(posedge clk); #1; if (core_rst) cnt++; end
    chk("R7 R8 disabled ignored", cnt, 0);
    @(negedge clk);
    clk_stall = 1'b0; cmp_out = 1'b1;

    wr(8'h04); chk("R7 mcd enable", mcd_en, 1);
    wr(8'h00); chk("R7 mcd disable", mcd_en, 0);
    wr(8'h20); chk("R8 cmp enable", cmp_rst_en, 1);
    wr(8'h00); chk("R8 cmp disable", cmp_rst_en, 0);

    // R10 R12: cause frozen, writes blocked during hold
    @(negedge clk); wdt_expire = 1'b1;
    @(negedge clk); wdt_expire = 1'b0;
    repeat (2) @(negedge clk);
    sw_rst_req = 1'b1;
    @(negedge clk); sw_rst_req = 1'b0;
    wr(8'h24);
    wait_idle("R10 exit");
    chk("R10 cause frozen", status, 8'h08);
    chk("R12 mcd write blocked", mcd_en, 0);
    chk("R12 cmp write blocked", cmp_rst_en, 0);

    // R11: watchdog prescaler
    chk("R11 wdt_en", wdt_en, 1);
    @(negedge clk);
    cnt = 0;
    repeat (120) begin @(posedge clk); #1; if (wdt_tick) cnt++; end
    chk("R11 ticks per 120", cnt, 120 / DIV);
    @(negedge clk); wdt_disable = 1'b1;
    @(negedge clk); wdt_disable = 1'b0;
    repeat (2) @(negedge clk);
    cnt = 0;
    repeat (48) begin @(posedge clk); #1; if (wdt_tick) cnt++; end
    chk("R11 no ticks when off", cnt, 0);
    chk("R11 wdt off", wdt_en, 0);
    @(negedge clk); sw_rst_req = 1'b1;
    @(negedge clk); sw_rst_req = 1'b0;
    wait_idle("R9 sw exit");
    chk("R11 wdt back on", wdt_en, 1);
    chk("R9 sw status", status, 8'h10);

    // sweep every mix of internal requests (bit0 sup,1 mcd,2 cmp,3 wdt,4 sw)
    for (int m = 1; m < 32; m++) begin
      logic [7:0] cfg;
      logic [7:0] exp_st;
      int exp_hi;
      cfg = (m[1] ? 8'h04 : 8'h00) | (m[2] ? 8'h20 : 8'h00);
      wr(cfg);
      if (m[0])      exp_st = 8'h02;
      else if (m[1]) exp_st = 8'h04;
      else if (m[2]) exp_st = 8'h20;
      else if (m[3]) exp_st = 8'h08;
      else           exp_st = 8'h10;
      exp_hi = 1 + HOLD + (m[0] ? 3 : 0);
      supmon_trip = m[0]; clk_stall = m[1]; cmp_out = ~m[2];
      wdt_expire = m[3]; sw_rst_req = m[4];
      @(posedge clk); #1;
      chk("R3 R7 R8 R9 entry", core_rst, 1);
      chk("R10 priority cause", status, exp_st);
      chk("R9 pull only for supply", pin_pull_low, m[0] ? 1 : 0);
      @(negedge clk);
      supmon_trip = 1'b0; clk_stall = 1'b0; cmp_out = 1'b1;
      wdt_expire = 1'b0; sw_rst_req = 1'b0;
      cnt = 1;
      repeat (HOLD + 20) begin @(posedge clk); #1; if (core_rst) cnt++; end
      chk("R2 hold length", cnt, exp_hi);
      chk("R10 cause kept", status, exp_st);
      chk("R4 supmon kept", supmon_en, 1);
      chk("R11 mcd cleared", mcd_en, 0);
      chk("R11 cmp cleared", cmp_rst_en, 0);
      chk("R11 wdt set", wdt_en, 1);
    end

    // R4: only power-on clears the monitor
    @(negedge clk); por_n = 1'b0;
    #1;
    chk("R4 por clears supmon", supmon_en, 0);
    chk("R1 por status", status, 8'h02);
    @(negedge clk); por_n = 1'b1;
    wait_idle("R1 second release");

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule